// File: doc/BRIEF.md
# Register Rename Unit with Ordered Free Pool

This unit renames architectural registers onto a larger unified physical register file. It has sixteen architectural registers. The physical file has 32 entries by default, and a parameter fixes the size at build time. Each dispatch can read two source registers and can name one destination. The unit returns the physical tags that currently hold the two sources and a ready flag for each. When the dispatch needs a destination, the unit also hands out a fresh physical tag. A speculative front map is written when an instruction dispatches. A separate committed map is written when an instruction retires.

Each physical register is in one of three states: free, allocated (renamed but not yet retired), or committed (it holds the architectural value). Allocation always picks the free register with the lowest index. A retire names an architectural register and its new physical register. That physical register becomes committed, and the register that held the previous committed value of the same architectural register goes back to the pool. A released register can only be handed out from the following cycle onward. If a dispatch needs a destination and the pool is empty, the stall output is raised and nothing changes. Result writebacks mark a physical register ready, and a source that is being written back in the same cycle is reported as ready immediately.

Top module: `reg_rename`

## Requirements
- R1: After synchronous reset, both maps send architectural register i to physical register i. Physical registers 0..ARCH_REGS-1 are committed and ready, and every other physical register is free.
- R2: `src_a_tag` and `src_b_tag` show, in the same cycle and without a clock, the front-map entries for `disp_src_a` and `disp_src_b`.
- R3: `dst_tag` is always the lowest-numbered free physical register. A dispatch with `disp_valid=1`, `disp_has_dst=1` and no stall writes that tag into the front map for `disp_dst`, and the mapping is visible from the next cycle.
- R4: A physical register given out by a dispatch reads as allocated from the next cycle. The physical register named by a retire reads as committed from the next cycle.
- R5: On a retire (`commit_valid=1`), the committed map entry for `commit_arch` becomes `commit_phys`. The physical register that entry held before is released and reads as free from the next cycle.
- R6: A register released in a cycle cannot be given out in that same cycle. If the pool was empty, the dispatch still stalls, and the released register is handed out in the next cycle.
- R7: `disp_stall` is 1 exactly when `disp_valid=1`, `disp_has_dst=1` and no physical register is free. A stalled dispatch changes no map or state. A dispatch without a destination never stalls and allocates nothing.
- R8: A newly allocated register is not ready until a writeback (`wb_valid`, `wb_phys`) marks it ready. `src_a_ready` and `src_b_ready` also report ready when the source tag is being written back in the same cycle.
- R9: `stat_state` reports the state of physical register `stat_idx` with the encoding 0 = free, 1 = allocated, 2 = committed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| disp_valid | input | 1 | Dispatch request this cycle |
| disp_has_dst | input | 1 | The dispatch writes a destination register |
| disp_src_a | input | ARCH_W | First source architectural register |
| disp_src_b | input | ARCH_W | Second source architectural register |
| disp_dst | input | ARCH_W | Destination architectural register |
| src_a_tag | output | PHYS_W | Physical tag for first source |
| src_b_tag | output | PHYS_W | Physical tag for second source |
| src_a_ready | output | 1 | First source value is available |
| src_b_ready | output | 1 | Second source value is available |
| dst_tag | output | PHYS_W | Lowest free physical register (given out on a firing dispatch) |
| disp_stall | output | 1 | Destination needed but pool empty |
| commit_valid | input | 1 | Retire notification |
| commit_arch | input | ARCH_W | Retiring architectural destination |
| commit_phys | input | PHYS_W | Retiring physical destination |
| wb_valid | input | 1 | Result writeback this cycle |
| wb_phys | input | PHYS_W | Physical register being written |
| stat_idx | input | PHYS_W | Physical register whose state is observed |
| stat_state | output | 2 | State of `stat_idx` (0 free, 1 allocated, 2 committed) |

## Verification
The bench builds the unit with its defaults: sixteen architectural and 32 physical registers. With those values the pool holds sixteen registers after reset, so a short burst of destination dispatches empties it. That makes the empty-pool stall, and the case where a register released in the stalling cycle is handed out only one cycle later, easy to reach. A long random phase mixes dispatch, retire and writeback. It repeatedly empties and refills the pool, so the lowest-index choice is checked across many different free-set patterns.

// File: rtl/rr_pkg.sv
package rr_pkg;

    localparam int ARCH_REGS_DEFAULT = 16;
    localparam int PHYS_REGS_DEFAULT = 32;

    typedef enum logic [1:0] {
        PR_FREE   = 2'd0,
        PR_ALLOC  = 2'd1,
        PR_COMMIT = 2'd2
    } preg_state_e;

    function automatic int idx_width(input int n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/rr_map_table.sv
module rr_map_table #(
    parameter int ENTRIES  = 16,
    parameter int TAG_W    = 5,
    parameter int RD_PORTS = 2,
    localparam int IDX_W   = rr_pkg::idx_width(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] rd_idx [RD_PORTS],
    output logic [TAG_W-1:0] rd_tag [RD_PORTS],
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag
);

    logic [TAG_W-1:0] tbl [ENTRIES];

    // Identity mapping out of reset; one write port.
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ENTRIES; i++) begin
                tbl[i] <= TAG_W'(i);
            end
        end else if (wr_en) begin
            tbl[wr_idx] <= wr_tag;
        end
    end

    for (genvar p = 0; p < RD_PORTS; p++) begin : g_rd
        assign rd_tag[p] = tbl[rd_idx[p]];
    end

endmodule

// File: rtl/rr_lowest_pick.sv
module rr_lowest_pick #(
    parameter int WIDTH = 32,
    localparam int IDX_W = rr_pkg::idx_width(WIDTH)
) (
    input  logic [WIDTH-1:0] vec,
    output logic             found,
    output logic [IDX_W-1:0] idx
);

    always_comb begin
        idx = '0;
        for (int i = WIDTH - 1; i >= 0; i--) begin
            if (vec[i]) begin
                idx = IDX_W'(i);
            end
        end
    end

    assign found = |vec;

endmodule

// File: rtl/rr_reg_state.sv
module rr_reg_state
    import rr_pkg::*;
#(
    parameter int ARCH_REGS = 16,
    parameter int PHYS_REGS = 32,
    localparam int TAG_W    = idx_width(PHYS_REGS)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 alloc_en,
    input  logic [TAG_W-1:0]     alloc_tag,
    input  logic                 commit_en,
    input  logic [TAG_W-1:0]     commit_tag,
    input  logic [TAG_W-1:0]     release_tag,
    input  logic                 wb_en,
    input  logic [TAG_W-1:0]     wb_tag,
    input  logic [TAG_W-1:0]     rdy_idx [2],
    output logic                 rdy_out [2],
    input  logic [TAG_W-1:0]     stat_idx,
    output preg_state_e          stat_out,
    output logic [PHYS_REGS-1:0] free_vec
);

    preg_state_e          state [PHYS_REGS];
    logic [PHYS_REGS-1:0] ready;
    logic [PHYS_REGS-1:0] commit_vec;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < PHYS_REGS; i++) begin
                state[i] <= (i < ARCH_REGS) ? PR_COMMIT : PR_FREE;
                ready[i] <= (i < ARCH_REGS);
            end
        end else begin
            if (wb_en) begin
                ready[wb_tag] <= 1'b1;
            end
            if (commit_en) begin
                state[commit_tag]  <= PR_COMMIT;
                state[release_tag] <= PR_FREE;
            end
            if (alloc_en) begin
                state[alloc_tag] <= PR_ALLOC;
                ready[alloc_tag] <= 1'b0;
            end
        end
    end

    always_comb begin
        for (int i = 0; i < PHYS_REGS; i++) begin
            free_vec[i]   = (state[i] == PR_FREE);
            commit_vec[i] = (state[i] == PR_COMMIT);
        end
    end

    for (genvar p = 0; p < 2; p++) begin : g_rdy
        assign rdy_out[p] = ready[rdy_idx[p]] | (wb_en && (wb_tag == rdy_idx[p]));
    end

    assign stat_out = state[stat_idx];

    // Allocation only ever takes a free register (R3).
    assert_alloc_from_free_R3: assert property (@(posedge clk) disable iff (rst)
        alloc_en |-> (state[alloc_tag] == PR_FREE));

    // A retiring register was previously allocated (R4).
    assert_commit_from_alloc_R4: assert property (@(posedge clk) disable iff (rst)
        commit_en |-> (state[commit_tag] == PR_ALLOC));

    // The released register was the committed one (R5).
    assert_release_was_committed_R5: assert property (@(posedge clk) disable iff (rst)
        commit_en |-> (state[release_tag] == PR_COMMIT));

    // Exactly one committed copy per architectural register (R5).
    assert_commit_count_R5: assert property (@(posedge clk) disable iff (rst)
        $countones(commit_vec) == ARCH_REGS);

    // A retired register takes committed state on the next edge (R4).
    assert_commit_lands_R4: assert property (@(posedge clk) disable iff (rst)
        commit_en |=> (state[$past(commit_tag)] == PR_COMMIT));

endmodule

// File: rtl/reg_rename.sv
module reg_rename
    import rr_pkg::*;
#(
    parameter int ARCH_REGS = ARCH_REGS_DEFAULT,
    parameter int PHYS_REGS = PHYS_REGS_DEFAULT,
    localparam int ARCH_W   = idx_width(ARCH_REGS),
    localparam int PHYS_W   = idx_width(PHYS_REGS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              disp_valid,
    input  logic              disp_has_dst,
    input  logic [ARCH_W-1:0] disp_src_a,
    input  logic [ARCH_W-1:0] disp_src_b,
    input  logic [ARCH_W-1:0] disp_dst,
    output logic [PHYS_W-1:0] src_a_tag,
    output logic [PHYS_W-1:0] src_b_tag,
    output logic              src_a_ready,
    output logic              src_b_ready,
    output logic [PHYS_W-1:0] dst_tag,
    output logic              disp_stall,
    input  logic              commit_valid,
    input  logic [ARCH_W-1:0] commit_arch,
    input  logic [PHYS_W-1:0] commit_phys,
    input  logic              wb_valid,
    input  logic [PHYS_W-1:0] wb_phys,
    input  logic [PHYS_W-1:0] stat_idx,
    output logic [1:0]        stat_state
);

    logic [ARCH_W-1:0]    front_rd_idx [2];
    logic [PHYS_W-1:0]    front_rd_tag [2];
    logic [ARCH_W-1:0]    back_rd_idx  [1];
    logic [PHYS_W-1:0]    back_rd_tag  [1];
    logic [PHYS_W-1:0]    rdy_idx      [2];
    logic                 rdy_out      [2];
    logic [PHYS_REGS-1:0] free_vec;
    logic [PHYS_REGS-1:0] below_mask;
    logic                 any_free;
    logic [PHYS_W-1:0]    pick_tag;
    logic                 need_dst;
    logic                 alloc_fire;
    preg_state_e          stat_e;

    assign front_rd_idx[0] = disp_src_a;
    assign front_rd_idx[1] = disp_src_b;
    assign back_rd_idx[0]  = commit_arch;

    assign need_dst   = disp_valid & disp_has_dst;
    assign alloc_fire = need_dst & any_free;
    assign disp_stall = need_dst & ~any_free;

    rr_map_table #(
        .ENTRIES (ARCH_REGS),
        .TAG_W   (PHYS_W),
        .RD_PORTS(2)
    ) u_front (
        .clk   (clk),
        .rst   (rst),
        .rd_idx(front_rd_idx),
        .rd_tag(front_rd_tag),
        .wr_en (alloc_fire),
        .wr_idx(disp_dst),
        .wr_tag(pick_tag)
    );

    rr_map_table #(
        .ENTRIES (ARCH_REGS),
        .TAG_W   (PHYS_W),
        .RD_PORTS(1)
    ) u_back (
        .clk   (clk),
        .rst   (rst),
        .rd_idx(back_rd_idx),
        .rd_tag(back_rd_tag),
        .wr_en (commit_valid),
        .wr_idx(commit_arch),
        .wr_tag(commit_phys)
    );

    rr_lowest_pick #(
        .WIDTH(PHYS_REGS)
    ) u_pick (
        .vec  (free_vec),
        .found(any_free),
        .idx  (pick_tag)
    );

    assign rdy_idx[0] = front_rd_tag[0];
    assign rdy_idx[1] = front_rd_tag[1];

    rr_reg_state #(
        .ARCH_REGS(ARCH_REGS),
        .PHYS_REGS(PHYS_REGS)
    ) u_state (
        .clk        (clk),
        .rst        (rst),
        .alloc_en   (alloc_fire),
        .alloc_tag  (pick_tag),
        .commit_en  (commit_valid),
        .commit_tag (commit_phys),
        .release_tag(back_rd_tag[0]),
        .wb_en      (wb_valid),
        .wb_tag     (wb_phys),
        .rdy_idx    (rdy_idx),
        .rdy_out    (rdy_out),
        .stat_idx   (stat_idx),
        .stat_out   (stat_e),
        .free_vec   (free_vec)
    );

    assign src_a_tag   = front_rd_tag[0];
    assign src_b_tag   = front_rd_tag[1];
    assign src_a_ready = rdy_out[0];
    assign src_b_ready = rdy_out[1];
    assign dst_tag     = pick_tag;
    assign stat_state  = stat_e;

    always_comb begin
        below_mask = '0;
        for (int i = 0; i < PHYS_REGS; i++) begin
            below_mask[i] = (PHYS_W'(i) < pick_tag);
        end
    end

    // No free register sits below the one handed out (R3).
    assert_lowest_first_R3: assert property (@(posedge clk) disable iff (rst)
        alloc_fire |-> ((free_vec & below_mask) == '0));

    // Stall only when the pool is truly empty (R7).
    assert_stall_only_empty_R7: assert property (@(posedge clk) disable iff (rst)
        disp_stall |-> (free_vec == '0));

    // A stalled dispatch leaves the pool untouched (R7).
    assert_stall_no_alloc_R7: assert property (@(posedge clk) disable iff (rst)
        (disp_stall && !commit_valid) |=> $stable(free_vec));

    // The handed-out tag reads as allocated next cycle (R4).
    assert_alloc_lands_R4: assert property (@(posedge clk) disable iff (rst)
        alloc_fire |=> (free_vec[$past(pick_tag)] == 1'b0));

endmodule

// File: tb/reg_rename_bench.sv
module reg_rename_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NA = 16;
    localparam int NP = 32;
    localparam int AW = 4;
    localparam int PW = 5;

    logic clk = 1'b0;
    logic rst;
    always #(CLK_PERIOD / 2) clk = ~clk;

    logic          disp_valid, disp_has_dst;
    logic [AW-1:0] disp_src_a, disp_src_b, disp_dst;
    logic [PW-1:0] src_a_tag, src_b_tag, dst_tag;
    logic          src_a_ready, src_b_ready, disp_stall;
    logic          commit_valid;
    logic [AW-1:0] commit_arch;
    logic [PW-1:0] commit_phys;
    logic          wb_valid;
    logic [PW-1:0] wb_phys;
    logic [PW-1:0] stat_idx;
    logic [1:0]    stat_state;

    reg_rename u_reg_rename (
        .clk(clk), .rst(rst),
        .disp_valid(disp_valid), .disp_has_dst(disp_has_dst),
        .disp_src_a(disp_src_a), .disp_src_b(disp_src_b), .disp_dst(disp_dst),
        .src_a_tag(src_a_tag), .src_b_tag(src_b_tag),
        .src_a_ready(src_a_ready), .src_b_ready(src_b_ready),
        .dst_tag(dst_tag), .disp_stall(disp_stall),
        .commit_valid(commit_valid), .commit_arch(commit_arch), .commit_phys(commit_phys),
        .wb_valid(wb_valid), .wb_phys(wb_phys),
        .stat_idx(stat_idx), .stat_state(stat_state)
    );

    // Behavioural reference: 0 free, 1 allocated, 2 committed
    int front [NA];
    int back  [NA];
    int st    [NP];
    bit rdy   [NP];
    int qa [$];
    int qp [$];
    int total = 0;
    int bad   = 0;

    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int lowest_free();
        for (int i = 0; i < NP; i++) begin
            if (st[i] == 0) return i;
        end
        return -1;
    endfunction

    // One cycle: drive, check outputs, then advance the model at the edge.
    task automatic cyc(input bit dv, input bit hd, input int sa, input int sb, input int dd,
                       input bit cv, input bit wv, input int wp, input int qi,
                       input string stat_req);
        int ca, cp, lf, ta, tb;
        bit fire;
        ca = 0; cp = 0;
        if (cv && qa.size() == 0) cv = 1'b0;
        if (cv) begin ca = qa[0]; cp = qp[0]; end
        @(negedge clk);
        disp_valid = dv; disp_has_dst = hd;
        disp_src_a = AW'(sa); disp_src_b = AW'(sb); disp_dst = AW'(dd);
        commit_valid = cv; commit_arch = AW'(ca); commit_phys = PW'(cp);
        wb_valid = wv; wb_phys = PW'(wp); stat_idx = PW'(qi);
        #1;
        lf = lowest_free();
        ta = front[sa]; tb = front[sb];
        chk("R2", "src_a_tag", int'(src_a_tag), ta);
        chk("R2", "src_b_tag", int'(src_b_tag), tb);
        chk("R8", "src_a_ready", int'(src_a_ready), int'(rdy[ta] || (wv && wp == ta)));
        chk("R8", "src_b_ready", int'(src_b_ready), int'(rdy[tb] || (wv && wp == tb)));
        chk("R7", "disp_stall", int'(disp_stall), int'(dv && hd && lf < 0));
        if (lf >= 0) chk("R3", "dst_tag", int'(dst_tag), lf);
        chk(stat_req, "stat_state", int'(stat_state), st[qi]);
        fire = dv && hd && (lf >= 0);
        @(posedge clk);
        if (cv) begin
            void'(qa.pop_front()); void'(qp.pop_front());
            st[back[ca]] = 0;
            back[ca] = cp;
            st[cp] = 2;
        end
        if (wv) rdy[wp] = 1'b1;
        if (fire) begin
            front[dd] = lf; st[lf] = 1; rdy[lf] = 1'b0;
            qa.push_back(dd); qp.push_back(lf);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", total, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst = 1'b1;
        disp_valid = 0; disp_has_dst = 0; disp_src_a = '0; disp_src_b = '0; disp_dst = '0;
        commit_valid = 0; commit_arch = '0; commit_phys = '0;
        wb_valid = 0; wb_phys = '0; stat_idx = '0;
        for (int i = 0; i < NA; i++) begin front[i] = i; back[i] = i; end
        for (int i = 0; i < NP; i++) begin st[i] = (i < NA) ? 2 : 0; rdy[i] = (i < NA); end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: identity maps and initial states, R9 encoding seen through stat port
        for (int i = 0; i < NP; i++) begin
            cyc(0, 0, i % NA, (i + 5) % NA, 0, 0, 0, 0, i, "R1 R9");
        end

        // Fill the pool: each dispatch reads the previous destination (R8 not ready)
        for (int i = 0; i < 16; i++) begin
            cyc(1, 1, (i + 15) % NA, i, i, 0, (i % 3 == 0) && i > 0, 16 + i - 1, 16 + i, "R4");
        end
        // Forward in the same cycle as writeback (R8)
        cyc(0, 0, 15, 14, 0, 0, 1, 31, 31, "R8");
        // Dispatch without destination never stalls (R7)
        cyc(1, 0, 3, 4, 7, 0, 0, 0, 16, "R7");
        // Empty pool: stall while a retire frees P0 in the same cycle (R6)
        cyc(1, 1, 2, 3, 5, 1, 0, 0, 0, "R5");
        chk("R6", "freed reg state after release", 0, st[0]);
        // Next cycle the released register is handed out (R6)
        cyc(1, 1, 5, 5, 5, 0, 0, 0, 0, "R6");
        chk("R6", "front map took released reg", 0, front[5]);
        chk("R6", "P16 committed", 2, st[16]);

        // Random mixed traffic
        for (int n = 0; n < 6000; n++) begin
            bit dv, hd, cv, wv;
            int wp;
            dv = ($urandom_range(0, 3) != 0);
            hd = ($urandom_range(0, 4) != 0);
            cv = ($urandom_range(0, 2) == 0);
            wv = ($urandom_range(0, 1) == 0) && qp.size() > 0;
            wp = (qp.size() > 0) ? qp[$urandom_range(0, qp.size() - 1)] : 0;
            cyc(dv, hd, $urandom_range(0, NA - 1), $urandom_range(0, NA - 1),
                $urandom_range(0, NA - 1), cv, wv, wp, $urandom_range(0, NP - 1), "R4 R5 R9");
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule